// File: doc/BRIEF.md
# Program/Erase Sequencer with Status Byte

This block is the internal engine that carries out one byte-program or one block-erase at a time for a non-volatile array. A command decoder gives it single-cycle strobes: start a program, start an erase, suspend, resume and clear. The array returns a verify-pass level. The block drives one phase signal at a time toward the array (precondition, erase pulse, program pulse, verify) and holds the captured target address and data steady for the whole operation. Every phase length is a cycle count set by a parameter.

The block keeps an 8-bit status byte that software can poll. Bit 7 is the ready flag, bit 6 the erase-suspended flag, bit 5 erase fail, bit 4 program fail and bit 3 supply fail. Bits 2..0 always read 0. The fail bits stay set until the clear strobe arrives. While the supply-fail bit is set, no new operation can start. An erase can be paused at the end of an erase pulse and later resumed. A resumed erase goes on with verification and does not repeat preconditioning.

Top module: `pe_ctrl`

## Requirements
- R1: After reset the status byte is 0x80 and no phase signal is active.
- R2: An accepted program start captures `addr_in`/`data_in` on `op_addr`/`op_data` and holds them to the end. It then drives `ph_program` for PRG_CYC cycles, followed by `ph_verify` for VFY_CYC cycles. If verify passes at the end of that window, the block returns to status 0x80.
- R3: When program verify fails, another program pulse and verify follow. After MAX_PRG_PULSES failed verifies, bit 4 is set and ready returns to 1.
- R4: An accepted erase start runs `ph_precond` for PRE_CYC cycles, then `ph_erase` for ERS_CYC cycles, then `ph_verify` for VFY_CYC cycles, in that order. At most one phase signal is active in any cycle.
- R5: When erase verify fails, another erase pulse and verify follow. After MAX_ERS_PULSES failed verifies, bit 5 is set and ready returns to 1.
- R6: Bits 5, 4 and 3 stay set across later cycles and later successful operations. Only a clear strobe resets them.
- R7: A start strobe while `supply_ok` is low is rejected. Ready stays 1, no phase starts, and bit 3 and the matching fail bit (4 for program, 5 for erase) are set.
- R8: While bit 3 is set, a start strobe is rejected even with `supply_ok` high, and the matching fail bit is set. After a clear, starts are accepted again.
- R9: If `supply_ok` goes low while an operation runs, every phase stops on the next cycle, ready returns to 1, and bit 3 and the matching fail bit are set.
- R10: A suspend strobe during an erase takes effect only when the current or next erase pulse ends. The block then stops all phases and shows status 0xC0 until a resume strobe arrives.
- R11: A resume strobe while suspended clears bits 7 and 6 on the next cycle. The erase then continues with a verify phase, and precondition is not run again.
- R12: A suspend strobe while idle or during a program is ignored. Status and phases are unaffected, and no later erase is suspended because of it.
- R13: Bit 7 is 0 whenever an operation is running (status 0x00 with no fail bits). Bits 2..0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_prog | input | 1 | Single-cycle strobe: start a byte program |
| start_erase | input | 1 | Single-cycle strobe: start a block erase |
| suspend_req | input | 1 | Single-cycle strobe: request erase pause |
| resume_req | input | 1 | Single-cycle strobe: continue a paused erase |
| clear_req | input | 1 | Single-cycle strobe: clear fail bits 5..3 |
| supply_ok | input | 1 | High while the high-voltage supply is valid |
| verify_pass | input | 1 | Array verify result, sampled in the last verify cycle |
| addr_in | input | ADDR_W | Target address offered with a start strobe |
| data_in | input | DATA_W | Program data offered with a start strobe |
| op_addr | output | ADDR_W | Captured target address |
| op_data | output | DATA_W | Captured program data |
| ph_precond | output | 1 | Precondition phase active |
| ph_erase | output | 1 | Erase pulse active |
| ph_program | output | 1 | Program pulse active |
| ph_verify | output | 1 | Verify phase active |
| status | output | 8 | Status byte |

## Verification
The embedded properties assume that the strobes are single-cycle pulses and that `start_prog` and `start_erase` are never raised together. The bench drives every strobe for exactly one clock, changes inputs only on falling edges, and issues each scenario's starts one at a time. The properties also assume that `verify_pass` and `supply_ok` are levels that stay steady across a verify window unless a scenario changes them on purpose. The bench sets `verify_pass` before each start or resume, and it drops `supply_ok` only in the supply scenarios.

// File: rtl/pe_pkg.sv
package pe_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE,
      ST_ERS,
      ST_EVFY,
      ST_PRG,
      ST_PVFY,
      ST_SUSP
   } pe_state_e;

   localparam int SB_READY  = 7;
   localparam int SB_SUSP   = 6;
   localparam int SB_EFAIL  = 5;
   localparam int SB_PFAIL  = 4;
   localparam int SB_SUPPLY = 3;
   localparam int SB_RSV_N  = 3;

endpackage

// File: rtl/pe_timer.sv
module pe_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (load)          cnt_q <= load_val;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);

   // a loaded window lasts at least one cycle before completing
   AST_TIMER_LOAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (load && load_val != '0) |=> !done); // R4

endmodule

// File: rtl/pe_status.sv
module pe_status
   import pe_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clear,
   input  logic       set_efail,
   input  logic       set_pfail,
   input  logic       set_supply,
   input  logic       ready,
   input  logic       suspended,
   output logic       sfail,
   output logic [7:0] status
);

   logic efail_q, pfail_q, sfail_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         efail_q <= 1'b0;
         pfail_q <= 1'b0;
         sfail_q <= 1'b0;
      end else begin
         efail_q <= set_efail  | (efail_q & ~clear);
         pfail_q <= set_pfail  | (pfail_q & ~clear);
         sfail_q <= set_supply | (sfail_q & ~clear);
      end
   end

   assign sfail = sfail_q;

   assign status[SB_READY]  = ready;
   assign status[SB_SUSP]   = suspended;
   assign status[SB_EFAIL]  = efail_q;
   assign status[SB_PFAIL]  = pfail_q;
   assign status[SB_SUPPLY] = sfail_q;

   for (genvar i = 0; i < SB_RSV_N; i++) begin : g_rsv
      assign status[i] = 1'b0;
   end

   AST_EFAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (efail_q && !clear) |=> efail_q); // R6
   AST_PFAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (pfail_q && !clear) |=> pfail_q); // R6
   AST_SUPPLY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (sfail_q && !clear) |=> sfail_q); // R6
   AST_SUSP_IMPLIES_READY: assert property (@(posedge clk) disable iff (!rst_n)
      suspended |-> ready); // R10

endmodule

// File: rtl/pe_seq.sv
module pe_seq
   import pe_pkg::*;
#(
   parameter int ADDR_W         = 17,
   parameter int DATA_W         = 8,
   parameter int CNT_W          = 4,
   parameter int PC_W           = 3,
   parameter int PRE_CYC        = 4,
   parameter int ERS_CYC        = 6,
   parameter int PRG_CYC        = 3,
   parameter int VFY_CYC        = 2,
   parameter int MAX_ERS_PULSES = 3,
   parameter int MAX_PRG_PULSES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_prog,
   input  logic              start_erase,
   input  logic              suspend_req,
   input  logic              resume_req,
   input  logic              supply_ok,
   input  logic              verify_pass,
   input  logic              sfail,
   input  logic              tmr_done,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] data_in,
   output logic              tmr_load,
   output logic [CNT_W-1:0]  tmr_val,
   output logic              set_efail,
   output logic              set_pfail,
   output logic              set_supply,
   output logic              ready,
   output logic              suspended,
   output logic              ph_precond,
   output logic              ph_erase,
   output logic              ph_program,
   output logic              ph_verify,
   output logic [ADDR_W-1:0] op_addr,
   output logic [DATA_W-1:0] op_data
);

   localparam logic [CNT_W-1:0] PRE_LD = CNT_W'(PRE_CYC - 1);
   localparam logic [CNT_W-1:0] ERS_LD = CNT_W'(ERS_CYC - 1);
   localparam logic [CNT_W-1:0] PRG_LD = CNT_W'(PRG_CYC - 1);
   localparam logic [CNT_W-1:0] VFY_LD = CNT_W'(VFY_CYC - 1);
   localparam logic [PC_W-1:0]  ERS_LAST = PC_W'(MAX_ERS_PULSES - 1);
   localparam logic [PC_W-1:0]  PRG_LAST = PC_W'(MAX_PRG_PULSES - 1);

   pe_state_e       state_q, state_d;
   logic [PC_W-1:0] pulses_q;
   logic            pend_q;
   logic            cnt_clr, cnt_inc, capture;
   logic            running, in_erase, reject;

   assign running  = state_q inside {ST_PRE, ST_ERS, ST_EVFY, ST_PRG, ST_PVFY};
   assign in_erase = state_q inside {ST_PRE, ST_ERS, ST_EVFY};
   assign reject   = sfail | ~supply_ok;

   always_comb begin
      state_d    = state_q;
      tmr_load   = 1'b0;
      tmr_val    = '0;
      set_efail  = 1'b0;
      set_pfail  = 1'b0;
      set_supply = 1'b0;
      cnt_clr    = 1'b0;
      cnt_inc    = 1'b0;
      capture    = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start_prog) begin
               if (reject) begin
                  set_pfail  = 1'b1;
                  set_supply = ~supply_ok;
               end else begin
                  state_d  = ST_PRG;
                  tmr_load = 1'b1;
                  tmr_val  = PRG_LD;
                  cnt_clr  = 1'b1;
                  capture  = 1'b1;
               end
            end else if (start_erase) begin
               if (reject) begin
                  set_efail  = 1'b1;
                  set_supply = ~supply_ok;
               end else begin
                  state_d  = ST_PRE;
                  tmr_load = 1'b1;
                  tmr_val  = PRE_LD;
                  cnt_clr  = 1'b1;
                  capture  = 1'b1;
               end
            end
         end
         ST_PRE: if (tmr_done) begin
            state_d  = ST_ERS;
            tmr_load = 1'b1;
            tmr_val  = ERS_LD;
         end
         ST_ERS: if (tmr_done) begin
            if (pend_q || suspend_req) begin
               state_d = ST_SUSP;
            end else begin
               state_d  = ST_EVFY;
               tmr_load = 1'b1;
               tmr_val  = VFY_LD;
            end
         end
         ST_EVFY: if (tmr_done) begin
            if (verify_pass) begin
               state_d = ST_IDLE;
            end else if (pulses_q == ERS_LAST) begin
               set_efail = 1'b1;
               state_d   = ST_IDLE;
            end else begin
               cnt_inc  = 1'b1;
               state_d  = ST_ERS;
               tmr_load = 1'b1;
               tmr_val  = ERS_LD;
            end
         end
         ST_PRG: if (tmr_done) begin
            state_d  = ST_PVFY;
            tmr_load = 1'b1;
            tmr_val  = VFY_LD;
         end
         ST_PVFY: if (tmr_done) begin
            if (verify_pass) begin
               state_d = ST_IDLE;
            end else if (pulses_q == PRG_LAST) begin
               set_pfail = 1'b1;
               state_d   = ST_IDLE;
            end else begin
               cnt_inc  = 1'b1;
               state_d  = ST_PRG;
               tmr_load = 1'b1;
               tmr_val  = PRG_LD;
            end
         end
         ST_SUSP: if (resume_req) begin
            state_d  = ST_EVFY;
            tmr_load = 1'b1;
            tmr_val  = VFY_LD;
         end
         default: state_d = ST_IDLE;
      endcase
      // supply loss while running overrides every other outcome
      if (running && !supply_ok) begin
         state_d    = ST_IDLE;
         tmr_load   = 1'b0;
         cnt_inc    = 1'b0;
         set_supply = 1'b1;
         set_efail  = in_erase;
         set_pfail  = ~in_erase;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         pulses_q <= '0;
         pend_q   <= 1'b0;
         op_addr  <= '0;
         op_data  <= '0;
      end else begin
         state_q <= state_d;
         if (cnt_clr)      pulses_q <= '0;
         else if (cnt_inc) pulses_q <= pulses_q + 1'b1;
         if (!in_erase)        pend_q <= 1'b0;
         else if (suspend_req) pend_q <= 1'b1;
         if (capture) begin
            op_addr <= addr_in;
            op_data <= data_in;
         end
      end
   end

   assign ready      = (state_q == ST_IDLE) || (state_q == ST_SUSP);
   assign suspended  = (state_q == ST_SUSP);
   assign ph_precond = (state_q == ST_PRE);
   assign ph_erase   = (state_q == ST_ERS);
   assign ph_program = (state_q == ST_PRG);
   assign ph_verify  = (state_q == ST_EVFY) || (state_q == ST_PVFY);

   AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ph_precond, ph_erase, ph_program, ph_verify})); // R4
   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_precond || ph_erase || ph_program || ph_verify) |-> !ready); // R13
   AST_ERS_RETRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      in_erase |-> (pulses_q <= ERS_LAST)); // R5
   AST_SUPPLY_GATES_START: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && sfail) |=> state_q == ST_IDLE); // R8
   AST_ABORT_ON_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !supply_ok) |=> (state_q == ST_IDLE)); // R9
   AST_SUSP_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state_q == ST_SUSP) |-> $past(state_q == ST_ERS)); // R10
   AST_RESUME_TO_VERIFY: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SUSP && resume_req) |=> (state_q == ST_EVFY)); // R11
   AST_IDLE_SUSP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && suspend_req) |=> !pend_q); // R12
   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (running && state_q == $past(state_q) && !capture) |-> $stable(op_addr)); // R2

endmodule

// File: rtl/pe_ctrl.sv
module pe_ctrl
   import pe_pkg::*;
#(
   parameter int ADDR_W         = 17,
   parameter int DATA_W         = 8,
   parameter int PRE_CYC        = 4,
   parameter int ERS_CYC        = 6,
   parameter int PRG_CYC        = 3,
   parameter int VFY_CYC        = 2,
   parameter int MAX_ERS_PULSES = 3,
   parameter int MAX_PRG_PULSES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_prog,
   input  logic              start_erase,
   input  logic              suspend_req,
   input  logic              resume_req,
   input  logic              clear_req,
   input  logic              supply_ok,
   input  logic              verify_pass,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] data_in,
   output logic [ADDR_W-1:0] op_addr,
   output logic [DATA_W-1:0] op_data,
   output logic              ph_precond,
   output logic              ph_erase,
   output logic              ph_program,
   output logic              ph_verify,
   output logic [7:0]        status
);

   localparam int MAX_PE  = (PRE_CYC > ERS_CYC) ? PRE_CYC : ERS_CYC;
   localparam int MAX_PV  = (PRG_CYC > VFY_CYC) ? PRG_CYC : VFY_CYC;
   localparam int MAX_CYC = (MAX_PE > MAX_PV) ? MAX_PE : MAX_PV;
   localparam int CNT_W   = ($clog2(MAX_CYC) > 0) ? $clog2(MAX_CYC) : 1;
   localparam int MAX_PUL = (MAX_ERS_PULSES > MAX_PRG_PULSES) ? MAX_ERS_PULSES : MAX_PRG_PULSES;
   localparam int PC_W    = ($clog2(MAX_PUL) > 0) ? $clog2(MAX_PUL) : 1;

   if (PRE_CYC < 1 || ERS_CYC < 1 || PRG_CYC < 1 || VFY_CYC < 1) begin : g_bad_cyc
      $error("pe_ctrl: every phase length must be at least one cycle");
   end
   if (MAX_ERS_PULSES < 1 || MAX_PRG_PULSES < 1) begin : g_bad_pulses
      $error("pe_ctrl: pulse limits must be at least one");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("pe_ctrl: address and data widths must be positive");
   end

   logic             tmr_load, tmr_done;
   logic [CNT_W-1:0] tmr_val;
   logic             set_efail, set_pfail, set_supply;
   logic             ready, suspended, sfail;

   pe_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .done     (tmr_done)
   );

   pe_seq #(
      .ADDR_W         (ADDR_W),
      .DATA_W         (DATA_W),
      .CNT_W          (CNT_W),
      .PC_W           (PC_W),
      .PRE_CYC        (PRE_CYC),
      .ERS_CYC        (ERS_CYC),
      .PRG_CYC        (PRG_CYC),
      .VFY_CYC        (VFY_CYC),
      .MAX_ERS_PULSES (MAX_ERS_PULSES),
      .MAX_PRG_PULSES (MAX_PRG_PULSES)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_prog  (start_prog),
      .start_erase (start_erase),
      .suspend_req (suspend_req),
      .resume_req  (resume_req),
      .supply_ok   (supply_ok),
      .verify_pass (verify_pass),
      .sfail       (sfail),
      .tmr_done    (tmr_done),
      .addr_in     (addr_in),
      .data_in     (data_in),
      .tmr_load    (tmr_load),
      .tmr_val     (tmr_val),
      .set_efail   (set_efail),
      .set_pfail   (set_pfail),
      .set_supply  (set_supply),
      .ready       (ready),
      .suspended   (suspended),
      .ph_precond  (ph_precond),
      .ph_erase    (ph_erase),
      .ph_program  (ph_program),
      .ph_verify   (ph_verify),
      .op_addr     (op_addr),
      .op_data     (op_data)
   );

   pe_status u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (clear_req),
      .set_efail  (set_efail),
      .set_pfail  (set_pfail),
      .set_supply (set_supply),
      .ready      (ready),
      .suspended  (suspended),
      .sfail      (sfail),
      .status     (status)
   );

endmodule

// File: tb/tb_pe_ctrl.sv
`timescale 1ns/1ps
module tb_pe_ctrl;

   localparam int ADDR_W = 17;
   localparam int DATA_W = 8;
   localparam int PRE = 4, ERS = 6, PRG = 3, VFY = 2, MAXE = 3, MAXP = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_prog = 0, start_erase = 0, suspend_req = 0, resume_req = 0, clear_req = 0;
   logic supply_ok = 1, verify_pass = 1;
   logic [ADDR_W-1:0] addr_in = '0;
   logic [DATA_W-1:0] data_in = '0;
   logic [ADDR_W-1:0] op_addr;
   logic [DATA_W-1:0] op_data;
   logic ph_precond, ph_erase, ph_program, ph_verify;
   logic [7:0] status;

   int checks = 0;
   int fails = 0;

   always #10 clk = ~clk;

   pe_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRE_CYC(PRE), .ERS_CYC(ERS),
             .PRG_CYC(PRG), .VFY_CYC(VFY), .MAX_ERS_PULSES(MAXE),
             .MAX_PRG_PULSES(MAXP)) dut (
      .clk(clk), .rst_n(rst_n), .start_prog(start_prog), .start_erase(start_erase),
      .suspend_req(suspend_req), .resume_req(resume_req), .clear_req(clear_req),
      .supply_ok(supply_ok), .verify_pass(verify_pass), .addr_in(addr_in),
      .data_in(data_in), .op_addr(op_addr), .op_data(op_data),
      .ph_precond(ph_precond), .ph_erase(ph_erase), .ph_program(ph_program),
      .ph_verify(ph_verify), .status(status));

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [3:0] phases();
      return {ph_precond, ph_erase, ph_program, ph_verify};
   endfunction

   task automatic pulse_prog();
      start_prog = 1; @(negedge clk); start_prog = 0;
   endtask
   task automatic pulse_erase();
      start_erase = 1; @(negedge clk); start_erase = 0;
   endtask
   task automatic pulse_susp();
      suspend_req = 1; @(negedge clk); suspend_req = 0;
   endtask
   task automatic pulse_resume();
      resume_req = 1; @(negedge clk); resume_req = 0;
   endtask
   task automatic pulse_clear();
      clear_req = 1; @(negedge clk); clear_req = 0;
   endtask

   // counts phase cycles until ready; flags precondition after an erase pulse
   task automatic run_to_ready(output int pre_c, output int ers_c, output int prg_c,
                               output int vfy_c, output bit order_ok, output bit saw_susp);
      int guard = 0;
      pre_c = 0; ers_c = 0; prg_c = 0; vfy_c = 0; order_ok = 1; saw_susp = 0;
      while (!status[7] && guard < 2000) begin
         if (ph_precond) begin pre_c++; if (ers_c > 0) order_ok = 0; end
         if (ph_erase) ers_c++;
         if (ph_program) prg_c++;
         if (ph_verify) vfy_c++;
         if (status[6]) saw_susp = 1;
         guard++;
         @(negedge clk);
      end
      if (guard >= 2000) check("RUN", "operation never finished", 0, 1);
   endtask

   task automatic t_reset();
      check("R1", "status after reset", status, 8'h80);
      check("R1", "phases after reset", phases(), 4'b0000);
   endtask

   task automatic t_prog_pass();
      int a, b, c, d; bit o, s;
      verify_pass = 1; addr_in = 17'h1A5; data_in = 8'h3C;
      pulse_prog();
      check("R2", "op_addr captured", op_addr, 17'h1A5);
      check("R2", "op_data captured", op_data, 8'h3C);
      check("R13", "status while busy", status, 8'h00);
      addr_in = 17'h0F0F; data_in = 8'hFF;
      run_to_ready(a, b, c, d, o, s);
      check("R2", "program pulse cycles", c, PRG);
      check("R2", "verify cycles", d, VFY);
      check("R2", "status after pass", status, 8'h80);
      check("R2", "op_addr held", op_addr, 17'h1A5);
   endtask

   task automatic t_prog_fail();
      int a, b, c, d; bit o, s;
      verify_pass = 0;
      pulse_prog();
      run_to_ready(a, b, c, d, o, s);
      check("R3", "program pulse cycles total", c, PRG * MAXP);
      check("R3", "verify cycles total", d, VFY * MAXP);
      check("R3", "status program fail", status, 8'h90);
      repeat (10) @(negedge clk);
      check("R6", "program fail sticky", status, 8'h90);
      pulse_clear();
      check("R6", "clear resets fail", status, 8'h80);
   endtask

   task automatic t_erase_pass();
      int a, b, c, d; bit o, s;
      verify_pass = 1;
      pulse_erase();
      check("R4", "first phase is precondition", phases(), 4'b1000);
      run_to_ready(a, b, c, d, o, s);
      check("R4", "precondition cycles", a, PRE);
      check("R4", "erase cycles", b, ERS);
      check("R4", "verify cycles", d, VFY);
      check("R4", "phase order", o, 1);
      check("R4", "status after erase", status, 8'h80);
   endtask

   task automatic t_erase_fail();
      int a, b, c, d; bit o, s;
      verify_pass = 0;
      pulse_erase();
      run_to_ready(a, b, c, d, o, s);
      check("R5", "precondition once", a, PRE);
      check("R5", "erase cycles total", b, ERS * MAXE);
      check("R5", "verify cycles total", d, VFY * MAXE);
      check("R5", "status erase fail", status, 8'hA0);
      verify_pass = 1;
      pulse_prog();
      run_to_ready(a, b, c, d, o, s);
      check("R6", "erase fail survives good program", status, 8'hA0);
      pulse_clear();
      check("R6", "clear after erase fail", status, 8'h80);
   endtask

   task automatic t_supply_start();
      int a, b, c, d; bit o, s;
      supply_ok = 0;
      pulse_erase();
      check("R7", "erase rejected status", status, 8'hA8);
      check("R7", "no phase on reject", phases(), 4'b0000);
      supply_ok = 1;
      pulse_prog();
      check("R8", "program rejected by supply bit", status, 8'hB8);
      check("R8", "no phase while supply bit set", phases(), 4'b0000);
      pulse_clear();
      check("R8", "cleared", status, 8'h80);
      verify_pass = 1;
      pulse_prog();
      check("R8", "program accepted after clear", phases(), 4'b0010);
      run_to_ready(a, b, c, d, o, s);
      check("R8", "program completes", status, 8'h80);
   endtask

   task automatic t_abort();
      int guard = 0;
      verify_pass = 0;
      pulse_erase();
      while (!ph_erase && guard < 100) begin guard++; @(negedge clk); end
      supply_ok = 0;
      @(negedge clk);
      check("R9", "phases stop on supply loss", phases(), 4'b0000);
      check("R9", "status after abort", status, 8'hA8);
      supply_ok = 1;
      pulse_clear();
      check("R9", "clear after abort", status, 8'h80);
   endtask

   task automatic t_suspend();
      int a, b, c, d, n, guard; bit o, s;
      verify_pass = 0;
      pulse_erase();
      guard = 0;
      while (!ph_erase && guard < 100) begin guard++; @(negedge clk); end
      n = 0;
      while (ph_erase && n < 100) begin
         n++;
         suspend_req = (n == 2);
         @(negedge clk);
      end
      suspend_req = 0;
      check("R10", "erase pulse runs to its end", n, ERS);
      check("R10", "status suspended", status, 8'hC0);
      check("R10", "no phase while suspended", phases(), 4'b0000);
      repeat (5) @(negedge clk);
      check("R10", "stays suspended", status, 8'hC0);
      verify_pass = 1;
      pulse_resume();
      check("R11", "status after resume", status, 8'h00);
      check("R11", "resume enters verify", phases(), 4'b0001);
      run_to_ready(a, b, c, d, o, s);
      check("R11", "no precondition after resume", a, 0);
      check("R11", "erase completes", status, 8'h80);
   endtask

   task automatic t_ignore_susp();
      int a, b, c, d; bit o, s;
      pulse_susp();
      repeat (3) @(negedge clk);
      check("R12", "idle suspend status", status, 8'h80);
      check("R12", "idle suspend phases", phases(), 4'b0000);
      verify_pass = 1;
      pulse_prog();
      pulse_susp();
      run_to_ready(a, b, c, d, o, s);
      check("R12", "program not suspended", s, 0);
      check("R12", "program finished", status, 8'h80);
      pulse_erase();
      run_to_ready(a, b, c, d, o, s);
      check("R12", "later erase not suspended", s, 0);
      check("R12", "later erase full pulse", b, ERS);
      check("R12", "later erase status", status, 8'h80);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_prog_pass();
      t_prog_fail();
      t_erase_pass();
      t_erase_fail();
      t_supply_start();
      t_abort();
      t_suspend();
      t_ignore_susp();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #2_000_000;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule